// File: doc/BRIEF.md
# Synchronous Burst SRAM Write Controller

This block models the control and write path of a flow-through synchronous burst SRAM. Every input is sampled on the rising clock edge. A start address can be captured by either of two address strobes. The processor strobe loads an address and never writes. The controller strobe loads an address and writes in the same cycle, so it can start a new burst or extend a running one. Cycles with neither strobe continue the current access. In such a cycle, a low step input moves the two low address bits on by one, wrapping modulo four. A high step input holds the address, which suspends the burst.

Write data is split into four byte lanes of nine bits each. A global write request writes all four lanes. Without it, a lane is written only when the byte-write enable and that lane's own strobe are both low. Reads are flow-through. After the edge that sets the current address, the stored word is driven in the same cycle while read enable is low. At any other time the output is released: the drive flag is low and the data bus is zero.

The sequencer has three states. ST_IDLE means no access is open. ST_BASE means the controller sits at a freshly loaded address. ST_STEP means the address has been stepped at least once. The transitions are as follows. T_LOAD goes from any state to ST_BASE on a strobe while selected. T_DESEL goes from any state to ST_IDLE on a strobe while not selected. T_ADV goes from ST_BASE or ST_STEP to ST_STEP on a continuation cycle with step low. T_SUSPEND keeps ST_BASE or ST_STEP unchanged on a continuation cycle with step high. T_WAIT keeps ST_IDLE when no strobe arrives.

Top module: `sburst_wr_ctrl`

## Requirements
- R1: The block is selected only when sel_a_n=0, sel_b_n=0 and sel_c=1. A strobe cycle while not selected loads no address, writes nothing and closes the access, so rd_drive is low afterwards.
- R2: A selected cycle with cpu_strb_n low loads ld_addr as the current address and writes nothing, whatever the write inputs are.
- R3: A selected cycle with cpu_strb_n high and ctl_strb_n low loads ld_addr and writes wr_data to that address in the same cycle, subject to the lane rules of R6 and R7.
- R4: When both strobes are low in one cycle, the processor strobe wins: the address is loaded and nothing is written.
- R5: In a cycle with both strobes high during an open access, step_n high keeps the address and writes to it. step_n low first adds one to address bits [1:0], modulo four, leaving the upper bits unchanged, and then writes to the new address.
- R6: During a write cycle, all_wr_n low writes all four lanes, regardless of lane_wr_en_n and lane_strb_n.
- R7: With all_wr_n high, lane i is written only when lane_wr_en_n is low and lane_strb_n[i] is low. Lane i occupies wr_data bits [9i+8:9i]. A lane that is not written keeps its old contents.
- R8: While an access is open and rd_en_n is low, rd_drive is high and rd_data carries the stored word at the current address in the cycle after the edge that set that address. In every other case rd_drive is low and rd_data is zero.
- R9: After reset, and after any deselect, no access is open. Continuation cycles then write nothing and leave rd_drive low until a selected strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_strb_n | input | 1 | Processor address strobe, loads without writing |
| ctl_strb_n | input | 1 | Controller address strobe, loads and writes |
| step_n | input | 1 | Low steps the burst address; high suspends it |
| sel_a_n | input | 1 | Active-low chip select A |
| sel_b_n | input | 1 | Active-low chip select B |
| sel_c | input | 1 | Active-high chip select C |
| all_wr_n | input | 1 | Global write, all lanes |
| lane_wr_en_n | input | 1 | Enable for the per-lane strobes |
| lane_strb_n | input | 4 | Per-lane write strobes, bit i selects lane i |
| rd_en_n | input | 1 | Read output enable |
| ld_addr | input | 8 | Address taken on a strobe |
| wr_data | input | 36 | Write data, four 9-bit lanes |
| rd_data | output | 36 | Read data, zero while released |
| rd_drive | output | 1 | High while rd_data is driven |

## Verification
The assertions check the following on every cycle. A processor strobe never writes. A selected strobe of either kind loads ld_addr. A suspended continuation holds the address, and a stepped one increments only the two low bits. A global write enables all lanes. No write happens while no access is open. An unselected strobe releases the output, and a high read enable keeps it released. Only the bench's scenarios can show that the data actually landed in the array. That covers wrap-around overwrites, lane merges from partial writes, the behaviour when both strobes are low, and the fact that a dropped write left earlier contents intact. The bench shows these by reading the words back and comparing them with its own shadow copy.

// File: rtl/sburst_pkg.sv
package sburst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_STEP = 2'd2
    } acc_state_e;
endpackage

// File: rtl/sburst_seq.sv
module sburst_seq
    import sburst_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_strb_n,
    input  logic              ctl_strb_n,
    input  logic              step_n,
    input  logic              chip_sel,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              wr_ok,
    output acc_state_e        state
);
    acc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] cur_q;
    logic              load_cpu, load_ctl, strobe, upd;
    logic [BURST_W-1:0] step_lo;

    assign load_cpu = !cpu_strb_n;
    assign load_ctl = cpu_strb_n && !ctl_strb_n;
    assign strobe   = load_cpu || load_ctl;
    assign step_lo  = cur_q[BURST_W-1:0] + BURST_W'(1);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe && chip_sel) state_d = ST_BASE;      // T_LOAD
                else                    state_d = ST_IDLE;      // T_WAIT / T_DESEL
            end
            ST_BASE, ST_STEP: begin
                if (strobe)      state_d = chip_sel ? ST_BASE : ST_IDLE; // T_LOAD / T_DESEL
                else if (!step_n) state_d = ST_STEP;                      // T_ADV
                else             state_d = state_q;                       // T_SUSPEND
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs: access address and write permission for this cycle
    always_comb begin
        eff_addr = cur_q;
        wr_ok    = 1'b0;
        upd      = 1'b0;
        if (strobe) begin
            eff_addr = ld_addr;
            wr_ok    = load_ctl && chip_sel;
            upd      = chip_sel;
        end else if (state_q != ST_IDLE) begin
            wr_ok = 1'b1;
            upd   = 1'b1;
            if (!step_n) eff_addr = {cur_q[ADDR_W-1:BURST_W], step_lo};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cur_q <= '0;
        else if (upd) cur_q <= eff_addr;
    end

    assign cur_addr = cur_q;
    assign state    = state_q;
endmodule

// File: rtl/sburst_lane_dec.sv
module sburst_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             wr_ok,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_strb_n,
    output logic [LANES-1:0] lane_we
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = wr_ok && (!all_wr_n || (!lane_wr_en_n && !lane_strb_n[g]));
    end
endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] mem_q [DEPTH];
        always_ff @(posedge clk) begin
            if (lane_we[g]) mem_q[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end
        assign rd_word[g*LANE_W +: LANE_W] = mem_q[rd_addr];
    end
endmodule

// File: rtl/sburst_wr_ctrl.sv
module sburst_wr_ctrl
    import sburst_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_strb_n,
    input  logic                    ctl_strb_n,
    input  logic                    step_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_strb_n,
    input  logic                    rd_en_n,
    input  logic [ADDR_W-1:0]       ld_addr,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_drive
);
    localparam int DATA_W = LANES * LANE_W;

    logic              chip_sel, wr_ok, active;
    logic [ADDR_W-1:0] cur_addr, eff_addr;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] rd_word;
    acc_state_e        state;

    assign chip_sel = !sel_a_n && !sel_b_n && sel_c;
    assign active   = (state != ST_IDLE);

    sburst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_strb_n (cpu_strb_n),
        .ctl_strb_n (ctl_strb_n),
        .step_n     (step_n),
        .chip_sel   (chip_sel),
        .ld_addr    (ld_addr),
        .cur_addr   (cur_addr),
        .eff_addr   (eff_addr),
        .wr_ok      (wr_ok),
        .state      (state)
    );

    sburst_lane_dec #(.LANES(LANES)) u_dec (
        .wr_ok        (wr_ok),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_strb_n  (lane_strb_n),
        .lane_we      (lane_we)
    );

    sburst_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .lane_we (lane_we),
        .wr_addr (eff_addr),
        .wr_data (wr_data),
        .rd_addr (cur_addr),
        .rd_word (rd_word)
    );

    assign rd_drive = !rd_en_n && active;
    assign rd_data  = rd_drive ? rd_word : '0;
endmodule

// File: rtl/sburst_wr_ctrl_chk.sv
module sburst_wr_ctrl_chk #(
    parameter int ADDR_W  = 8,
    parameter int LANES   = 4,
    parameter int BURST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_strb_n,
    input logic              ctl_strb_n,
    input logic              step_n,
    input logic              chip_sel,
    input logic              all_wr_n,
    input logic              rd_en_n,
    input logic [ADDR_W-1:0] ld_addr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [LANES-1:0]  lane_we,
    input logic              active,
    input logic              rd_drive
);
    AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strb_n || !ctl_strb_n) && !chip_sel |=> !rd_drive); // R1
    AST_CPU_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_strb_n |-> lane_we == '0); // R4
    AST_CPU_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_strb_n && chip_sel |=> cur_addr == $past(ld_addr)); // R2
    AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_strb_n && !ctl_strb_n && chip_sel |=> cur_addr == $past(ld_addr)); // R3
    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        active && cpu_strb_n && ctl_strb_n && step_n |=> $stable(cur_addr)); // R5
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        active && cpu_strb_n && ctl_strb_n && !step_n |=>
        (cur_addr[BURST_W-1:0] == $past(cur_addr[BURST_W-1:0]) + BURST_W'(1)) &&
        (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W]))); // R5
    AST_GLOBAL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !all_wr_n && active && cpu_strb_n && ctl_strb_n |-> &lane_we); // R6
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !active && cpu_strb_n && ctl_strb_n |-> lane_we == '0); // R9
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_n |-> !rd_drive); // R8
endmodule

bind sburst_wr_ctrl sburst_wr_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .LANES   (LANES),
    .BURST_W (BURST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_strb_n (cpu_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .step_n     (step_n),
    .chip_sel   (chip_sel),
    .all_wr_n   (all_wr_n),
    .rd_en_n    (rd_en_n),
    .ld_addr    (ld_addr),
    .cur_addr   (cur_addr),
    .lane_we    (lane_we),
    .active     (active),
    .rd_drive   (rd_drive)
);

// File: tb/sburst_wr_ctrl_bench.sv
module sburst_wr_ctrl_bench;
    localparam int AW = 8;
    localparam int DW = 36;
    localparam int NV = 26;

    typedef struct packed {
        logic          cpu_n;
        logic          ctl_n;
        logic          step_n;
        logic [1:0]    sel;
        logic          gw_n;
        logic          bwe_n;
        logic [3:0]    bw_n;
        logic          oe_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          exp_drv;
        logic [AW-1:0] exp_addr;
        logic [3:0]    req;
    } vec_t;

    // sel code: 0 selected, 1 sel_a_n high, 2 sel_b_n high, 3 sel_c low
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,1'b1,2'd0,1'b0,1'b0,4'b0000,1'b1,8'h10,36'h0AAAAAAAA,1'b0,8'h10,4'd2}, // R2 load, no write
        '{1'b1,1'b1,1'b1,2'd0,1'b0,1'b1,4'b1111,1'b1,8'h00,36'h123456789,1'b0,8'h10,4'd6}, // R6 write loaded addr
        '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b1,4'b1111,1'b1,8'h00,36'h2468ACE02,1'b0,8'h11,4'd5}, // R5
        '{1'b1,1'b1,1'b0,2'd0,1'b1,1'b0,4'b0000,1'b1,8'h00,36'h3C3C3C3C3,1'b0,8'h12,4'd7},
        '{1'b1,1'b1,1'b0,2'd0,1'b1,1'b0,4'b0000,1'b1,8'h00,36'h4A5B6C7D8,1'b0,8'h13,4'd7},
        '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b1,4'b1111,1'b1,8'h00,36'h55555AAAA,1'b0,8'h10,4'd5}, // wrap
        '{1'b1,1'b0,1'b1,2'd0,1'b0,1'b1,4'b1111,1'b1,8'h2E,36'h600000006,1'b0,8'h2E,4'd3}, // R3
        '{1'b1,1'b1,1'b0,2'd0,1'b1,1'b0,4'b0000,1'b1,8'h00,36'h7E7E7E7E7,1'b0,8'h2F,4'd5},
        '{1'b1,1'b1,1'b1,2'd0,1'b1,1'b1,4'b0000,1'b1,8'h00,36'h0FFFFFFF0,1'b0,8'h2F,4'd7}, // suspend, gated
        '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b1,4'b1111,1'b1,8'h00,36'h999999999,1'b0,8'h2C,4'd5}, // wrap upper fixed
        '{1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,4'b1010,1'b1,8'h2F,36'hABCDEF012,1'b0,8'h2F,4'd3}, // extend, partial
        '{1'b0,1'b0,1'b1,2'd0,1'b0,1'b0,4'b0000,1'b0,8'h10,36'hBBBBBBBBB,1'b1,8'h10,4'd4}, // R4
        '{1'b1,1'b1,1'b0,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h00,36'h000000000,1'b1,8'h11,4'd8}, // R8
        '{1'b0,1'b1,1'b1,2'd2,1'b0,1'b1,4'b1111,1'b0,8'h2E,36'hCCCCCCCCC,1'b0,8'h00,4'd1}, // R1
        '{1'b1,1'b1,1'b0,2'd0,1'b0,1'b1,4'b1111,1'b0,8'h00,36'hDDDDDDDDD,1'b0,8'h00,4'd9}, // R9
        '{1'b0,1'b1,1'b1,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h2F,36'h000000000,1'b1,8'h2F,4'd7}, // R7 merge
        '{1'b1,1'b1,1'b0,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h00,36'h000000000,1'b1,8'h2C,4'd8},
        '{1'b1,1'b0,1'b1,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h12,36'h000000000,1'b1,8'h12,4'd8},
        '{1'b1,1'b0,1'b1,2'd0,1'b1,1'b1,4'b0000,1'b0,8'h13,36'hEEEEEEEEE,1'b1,8'h13,4'd7}, // lane enable gate
        '{1'b1,1'b0,1'b1,2'd0,1'b1,1'b0,4'b0111,1'b1,8'h13,36'hF0F0F0F0F,1'b0,8'h13,4'd7}, // lane 3 only
        '{1'b0,1'b1,1'b1,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h13,36'h000000000,1'b1,8'h13,4'd7},
        '{1'b0,1'b1,1'b1,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h11,36'h000000000,1'b1,8'h11,4'd9},
        '{1'b1,1'b0,1'b1,2'd3,1'b0,1'b1,4'b1111,1'b0,8'h12,36'h123123123,1'b0,8'h00,4'd1},
        '{1'b0,1'b1,1'b1,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h12,36'h000000000,1'b1,8'h12,4'd1},
        '{1'b0,1'b1,1'b1,2'd1,1'b1,1'b1,4'b1111,1'b0,8'h12,36'h000000000,1'b0,8'h00,4'd1},
        '{1'b1,1'b1,1'b0,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h00,36'h000000000,1'b0,8'h00,4'd9}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_strb_n, ctl_strb_n, step_n, sel_a_n, sel_b_n, sel_c;
    logic          all_wr_n, lane_wr_en_n, rd_en_n;
    logic [3:0]    lane_strb_n;
    logic [AW-1:0] ld_addr;
    logic [DW-1:0] wr_data, rd_data;
    logic          rd_drive;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [DW-1:0] shadow [1<<AW];
    bit m_active = 1'b0;

    always #10 clk = ~clk;

    sburst_wr_ctrl u_sburst_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
        .step_n(step_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_strb_n(lane_strb_n),
        .rd_en_n(rd_en_n), .ld_addr(ld_addr), .wr_data(wr_data),
        .rd_data(rd_data), .rd_drive(rd_drive)
    );

    task automatic drive(input vec_t v);
        cpu_strb_n = v.cpu_n; ctl_strb_n = v.ctl_n; step_n = v.step_n;
        sel_a_n = (v.sel == 2'd1); sel_b_n = (v.sel == 2'd2); sel_c = (v.sel != 2'd3);
        all_wr_n = v.gw_n; lane_wr_en_n = v.bwe_n; lane_strb_n = v.bw_n;
        rd_en_n = v.oe_n; ld_addr = v.addr; wr_data = v.data;
    endtask

    // reference model from R1-style rules, applied after the edge
    task automatic model(input vec_t v);
        bit sel_ok, strobe, wok;
        logic [3:0] lanes;
        sel_ok = (v.sel == 2'd0);
        strobe = !v.cpu_n || !v.ctl_n;
        wok = strobe ? (v.cpu_n && !v.ctl_n && sel_ok) : m_active;
        lanes = !v.gw_n ? 4'hF : (!v.bwe_n ? ~v.bw_n : 4'h0);
        if (wok)
            for (int i = 0; i < 4; i++)
                if (lanes[i]) shadow[v.exp_addr][9*i +: 9] = v.data[9*i +: 9];
        if (strobe) m_active = sel_ok;
    endtask

    task automatic check(input bit exp_drv, input logic [AW-1:0] a, input int req);
        logic [DW-1:0] exp_d;
        exp_d = exp_drv ? shadow[a] : '0;
        tests++;
        if (rd_drive !== exp_drv || rd_data !== exp_d) begin
            fails++;
            $display("FAIL R%0d: drive=%b data=%h expected drive=%b data=%h",
                     req, rd_drive, rd_data, exp_drv, exp_d);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        vec_t idle_v;
        for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;
        idle_v = '{1'b1,1'b1,1'b1,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h00,36'h0,1'b0,8'h00,4'd9};
        rst_n = 1'b0;
        drive(idle_v);
        repeat (3) @(negedge clk);
        check(1'b0, 8'h00, 9);  // R9: reset leaves output released
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(VECS[k]);
            @(posedge clk);
            @(negedge clk);
            model(VECS[k]);
            check(VECS[k].exp_drv, VECS[k].exp_addr, int'(VECS[k].req));
        end

        // R8: load and read, then reset mid-access
        drive('{1'b0,1'b1,1'b1,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h10,36'h0,1'b1,8'h10,4'd8});
        @(posedge clk); @(negedge clk);
        model('{1'b0,1'b1,1'b1,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h10,36'h0,1'b1,8'h10,4'd8});
        check(1'b1, 8'h10, 8);
        rst_n = 1'b0;
        @(negedge clk);
        check(1'b0, 8'h00, 9);  // R9: reset closes the access
        m_active = 1'b0;
        rst_n = 1'b1;
        // R9: continuation with global write after reset must write nothing
        drive('{1'b1,1'b1,1'b1,2'd0,1'b0,1'b1,4'b1111,1'b0,8'h00,36'h777777777,1'b0,8'h00,4'd9});
        @(posedge clk); @(negedge clk);
        check(1'b0, 8'h00, 9);
        drive('{1'b0,1'b1,1'b1,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h00,36'h0,1'b1,8'h00,4'd9});
        @(posedge clk); @(negedge clk);
        m_active = 1'b1;
        check(1'b1, 8'h00, 9);  // R9: location 0 (reset address) untouched
        drive('{1'b0,1'b1,1'b1,2'd0,1'b1,1'b1,4'b1111,1'b0,8'h10,36'h0,1'b1,8'h10,4'd9});
        @(posedge clk); @(negedge clk);
        check(1'b1, 8'h10, 9);  // R9: earlier contents kept

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule